// File: doc/BRIEF.md
# Intercept-Histogram Track Segment Finder

This block searches for one straight track segment per event in a single drift-tube chamber. An upstream coarse stage delivers one slope estimate per event, and this slope stays fixed while the event is processed. Only the intercept of the line is searched. Next comes a stream of hits. Each hit carries the coordinates of its anode wire and the measured drift radius. The radius is the perpendicular distance from the wire to the track.

A single hit cannot tell which side of the wire the track passed. The block therefore forms two candidate intercepts for every hit, one for each side, and casts both as votes into a small histogram of intercepts. This settles the side ambiguity without a two-dimensional accumulator. Hits are buffered while they vote. After the hit flagged as the last of the event, the block scans the histogram for its fullest bin. It then replays the buffered hits and sends downstream every hit whose intercept falls in that bin, together with the resolved intercept and the side that matched. The downstream stage is the precise line fitter.

The controller steps through six states:
- ST_IDLE: the block waits for a seed.
- ST_SQRT: the slope-dependent scale factor is computed.
- ST_ACCUM: hits are taken and votes are cast.
- ST_PEAK: the bins are scanned one per cycle.
- ST_REPLAY: the buffered hits are emitted.
- ST_DONE: the one-cycle result pulse.

The transitions are:
- seed accepted: ST_IDLE to ST_SQRT.
- factor ready: ST_SQRT to ST_ACCUM.
- last hit taken: ST_ACCUM to ST_PEAK.
- scan complete with a valid peak: ST_PEAK to ST_REPLAY.
- scan complete without a valid peak: ST_PEAK to ST_DONE.
- final buffered hit handled: ST_REPLAY to ST_DONE.
- pulse given: ST_DONE to ST_IDLE.

Top module: `hough_seg_finder`

## Requirements
- R1: After reset, seed_ready is 1, and in_ready, out_valid and seg_done are all 0.
- R2: The scale factor is k = floor(sqrt(2^(2·FRAC) + m²)), with the slope m in fixed point with FRAC fractional bits. Each hit gives two intercepts, bp = y + ((k·r)>>FRAC) − ((m·z)>>>FRAC) and bn = y − ((k·r)>>FRAC) − ((m·z)>>>FRAC). All shifts are arithmetic and floor toward minus infinity. out_b carries whichever of the two was emitted.
- R3: A vote at intercept b goes to bin (b − cfg_win_lo) >> BIN_SHIFT. A vote for which b − cfg_win_lo is negative, or for which this bin is NBINS or more, is dropped.
- R4: All bin counters are cleared when a seed is accepted. A counter saturates at 2^CNT_W − 1 and does not wrap. seg_peak_cnt reports the saturated count.
- R5: seg_peak_bin is the bin holding the highest count. When several bins tie, the lowest index wins. seg_peak_cnt is that count.
- R6: seg_found is 1 only when the peak count is at least cfg_min_cnt and is nonzero. When seg_found is 0, no hit is emitted and seg_done rises NBINS cycles after the edge that took the last hit.
- R7: Buffered hits are replayed in arrival order. A hit is emitted when bp falls in the peak bin (out_neg = 0). Otherwise it is emitted when bn falls in the peak bin (out_neg = 1). Otherwise it is skipped.
- R8: While out_valid is 1 and out_ready is 0, all output fields hold steady, and no hit is lost or duplicated.
- R9: Only the first DEPTH hits of an event are buffered and vote. Any further hits are accepted but have no effect on the histogram or on the replay.
- R10: seed_ready is 1 only in ST_IDLE, and in_ready is 1 only in ST_ACCUM. seg_done is a one-cycle pulse. With out_ready held at 1, seg_done rises NBINS + (number of buffered hits) cycles after the edge that took the last hit, when a segment is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_valid | input | 1 | A slope seed is offered |
| seed_ready | output | 1 | The block can take a seed |
| seed_slope | input | SLOPE_W | Signed slope, FRAC fractional bits |
| cfg_win_lo | input | COORD_W | Signed lower edge of the intercept window, sampled with the seed |
| cfg_min_cnt | input | CNT_W | Minimum peak count for a segment, sampled with the seed |
| in_valid | input | 1 | A hit is offered |
| in_ready | output | 1 | The block can take a hit |
| in_z | input | COORD_W | Signed wire coordinate along the chamber |
| in_y | input | COORD_W | Signed wire coordinate across the chamber |
| in_r | input | R_W | Unsigned drift radius |
| in_last | input | 1 | Marks the final hit of the event |
| out_valid | output | 1 | A selected hit is presented |
| out_ready | input | 1 | Downstream takes the selected hit |
| out_z | output | COORD_W | Wire z of the selected hit |
| out_y | output | COORD_W | Wire y of the selected hit |
| out_r | output | R_W | Drift radius of the selected hit |
| out_b | output | COORD_W+SLOPE_W+2 | Resolved intercept |
| out_neg | output | 1 | 1 when the negative-side intercept matched |
| seg_done | output | 1 | One-cycle end-of-event pulse |
| seg_found | output | 1 | A segment was found in this event |
| seg_peak_bin | output | log2(NBINS) | Index of the peak bin |
| seg_peak_cnt | output | CNT_W | Count in the peak bin |

## Verification
The bench takes the edge that accepts the last hit as cycle zero. After that edge, the peak result needs exactly NBINS cycles of scanning. Each buffered hit then takes one replay cycle while out_ready is held high. The bench therefore expects seg_done at cycle NBINS when no segment is found, and at cycle NBINS plus the stored-hit count otherwise. It counts falling edges from cycle zero and checks the pulse at exactly that count. While the block is in ST_SQRT, the bench polls in_ready instead of fixing the handshake cycle. Every output is sampled on the falling edge. A hit counts as transferred only when out_valid and out_ready are both seen high at that sample, so stalled cycles are neither counted nor skipped.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQRT,
        ST_ACCUM,
        ST_PEAK,
        ST_REPLAY,
        ST_DONE
    } hsf_state_e;
endpackage

// File: rtl/hsf_sqrt.sv
// Bit-serial floor square root of (2^(2*FRAC) + slope^2), one result bit per cycle.
module hsf_sqrt #(
    parameter int SLOPE_W = 8,
    parameter int FRAC    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic signed [SLOPE_W-1:0] slope,
    output logic        [SLOPE_W-1:0] k_o,
    output logic                      done_o
);
    localparam int SQ_W  = 2 * SLOPE_W;
    localparam int IDX_W = $clog2(SLOPE_W);

    logic        [SQ_W-1:0]    rad_q;
    logic        [SLOPE_W-1:0] root_q;
    logic        [IDX_W-1:0]   pos_q;
    logic                      busy_q;
    logic signed [SQ_W-1:0]    slope_sq;
    logic        [SQ_W-1:0]    rad_init;
    logic        [SLOPE_W-1:0] trial;
    logic        [SQ_W-1:0]    trial_sq;

    assign slope_sq = slope * slope;
    assign rad_init = $unsigned(slope_sq) + (SQ_W'(1) << (2 * FRAC));
    assign trial    = root_q | (SLOPE_W'(1) << pos_q);
    assign trial_sq = SQ_W'(trial) * SQ_W'(trial);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_q  <= '0;
            root_q <= '0;
            pos_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            rad_q  <= rad_init;
            root_q <= '0;
            pos_q  <= IDX_W'(SLOPE_W - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (trial_sq <= rad_q) root_q <= trial;
            if (pos_q == '0) busy_q <= 1'b0;
            else             pos_q  <= pos_q - 1'b1;
        end
    end

    assign k_o    = root_q;
    assign done_o = busy_q && (pos_q == '0);
endmodule

// File: rtl/hsf_intercept.sv
// Two side-intercepts of one hit and their histogram bins.
module hsf_intercept #(
    parameter int COORD_W   = 10,
    parameter int R_W       = 6,
    parameter int SLOPE_W   = 8,
    parameter int FRAC      = 4,
    parameter int NBINS     = 16,
    parameter int BIN_SHIFT = 2
) (
    input  logic        [SLOPE_W-1:0]                k,
    input  logic signed [SLOPE_W-1:0]                slope,
    input  logic signed [COORD_W-1:0]                z,
    input  logic signed [COORD_W-1:0]                y,
    input  logic        [R_W-1:0]                    r,
    input  logic signed [COORD_W-1:0]                win_lo,
    output logic signed [COORD_W+SLOPE_W+1:0]        bp,
    output logic signed [COORD_W+SLOPE_W+1:0]        bn,
    output logic                                     p_ok,
    output logic                                     n_ok,
    output logic        [$clog2(NBINS)-1:0]          p_bin,
    output logic        [$clog2(NBINS)-1:0]          n_bin
);
    localparam int BW    = COORD_W + SLOPE_W + 2;
    localparam int BIN_W = $clog2(NBINS);
    localparam int PR_W  = SLOPE_W + R_W;
    localparam int PM_W  = SLOPE_W + COORD_W;

    logic        [PR_W-1:0] kr_u;
    logic signed [PM_W-1:0] mz;
    logic signed [BW-1:0]   kr_s, mz_s, y_s, w_s, off_p, off_n;

    assign kr_u = k * r;
    assign mz   = slope * z;
    assign kr_s = $signed(BW'(kr_u >> FRAC));
    assign mz_s = BW'(mz >>> FRAC);
    assign y_s  = BW'(y);
    assign w_s  = BW'(win_lo);

    assign bp = y_s + kr_s - mz_s;
    assign bn = y_s - kr_s - mz_s;

    assign off_p = bp - w_s;
    assign off_n = bn - w_s;
    assign p_ok  = !off_p[BW-1] && ((off_p >>> BIN_SHIFT) < $signed(BW'(NBINS)));
    assign n_ok  = !off_n[BW-1] && ((off_n >>> BIN_SHIFT) < $signed(BW'(NBINS)));
    assign p_bin = off_p[BIN_SHIFT +: BIN_W];
    assign n_bin = off_n[BIN_SHIFT +: BIN_W];
endmodule

// File: rtl/hsf_histo.sv
// Saturating vote counters, one per intercept bin, with indexed read.
module hsf_histo #(
    parameter int NBINS = 16,
    parameter int CNT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     vote,
    input  logic                     p_ok,
    input  logic [$clog2(NBINS)-1:0] p_bin,
    input  logic                     n_ok,
    input  logic [$clog2(NBINS)-1:0] n_bin,
    input  logic [$clog2(NBINS)-1:0] rd_idx,
    output logic [CNT_W-1:0]         rd_cnt
);
    localparam int BIN_W = $clog2(NBINS);
    localparam logic [CNT_W:0] CMAX = (CNT_W+1)'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] cnt_q [NBINS];

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        logic [1:0]     inc;
        logic [CNT_W:0] sum;
        assign inc = {1'b0, p_ok && (p_bin == BIN_W'(g))}
                   + {1'b0, n_ok && (n_bin == BIN_W'(g))};
        assign sum = {1'b0, cnt_q[g]} + (CNT_W+1)'(inc);
        always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt_q[g] <= '0;
            else if (vote)     cnt_q[g] <= (sum > CMAX) ? CMAX[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

    assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/hough_seg_finder.sv
module hough_seg_finder #(
    parameter int COORD_W   = 10,
    parameter int R_W       = 6,
    parameter int SLOPE_W   = 8,
    parameter int FRAC      = 4,
    parameter int NBINS     = 16,
    parameter int BIN_SHIFT = 2,
    parameter int CNT_W     = 3,
    parameter int DEPTH     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              seed_valid,
    output logic                              seed_ready,
    input  logic signed [SLOPE_W-1:0]         seed_slope,
    input  logic signed [COORD_W-1:0]         cfg_win_lo,
    input  logic        [CNT_W-1:0]           cfg_min_cnt,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic signed [COORD_W-1:0]         in_z,
    input  logic signed [COORD_W-1:0]         in_y,
    input  logic        [R_W-1:0]             in_r,
    input  logic                              in_last,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic signed [COORD_W-1:0]         out_z,
    output logic signed [COORD_W-1:0]         out_y,
    output logic        [R_W-1:0]             out_r,
    output logic signed [COORD_W+SLOPE_W+1:0] out_b,
    output logic                              out_neg,
    output logic                              seg_done,
    output logic                              seg_found,
    output logic        [$clog2(NBINS)-1:0]   seg_peak_bin,
    output logic        [CNT_W-1:0]           seg_peak_cnt
);
    import hsf_pkg::*;

    localparam int BW    = COORD_W + SLOPE_W + 2;
    localparam int BIN_W = $clog2(NBINS);
    localparam int A_W   = $clog2(DEPTH);
    localparam int N_W   = $clog2(DEPTH + 1);

    hsf_state_e state_q, state_d;

    logic signed [SLOPE_W-1:0] m_q;
    logic signed [COORD_W-1:0] win_q;
    logic        [CNT_W-1:0]   min_q;
    logic        [N_W-1:0]     n_q, rd_q;
    logic        [BIN_W-1:0]   scan_q, best_bin_q;
    logic        [CNT_W-1:0]   best_cnt_q;
    logic                      found_q;

    logic signed [COORD_W-1:0] bz_q [DEPTH];
    logic signed [COORD_W-1:0] by_q [DEPTH];
    logic        [R_W-1:0]     br_q [DEPTH];

    logic        [SLOPE_W-1:0] k_w;
    logic                      sq_done;
    logic signed [COORD_W-1:0] sel_z, sel_y;
    logic        [R_W-1:0]     sel_r;
    logic signed [BW-1:0]      bp_w, bn_w;
    logic                      p_ok_w, n_ok_w;
    logic        [BIN_W-1:0]   p_bin_w, n_bin_w;
    logic        [CNT_W-1:0]   cur_cnt, nb_cnt;
    logic                      seed_take, hit_take, hit_store, better, peak_ok, scan_last;
    logic                      hit_p, hit_n, emit, step, rd_last;
    logic        [A_W-1:0]     rd_idx;

    assign seed_take = (state_q == ST_IDLE) && seed_valid;
    assign hit_take  = (state_q == ST_ACCUM) && in_valid;
    assign hit_store = hit_take && (n_q < N_W'(DEPTH));
    assign rd_idx    = rd_q[A_W-1:0];

    // Shared intercept datapath: live hit while accumulating, buffered hit while replaying.
    assign sel_z = (state_q == ST_ACCUM) ? in_z : bz_q[rd_idx];
    assign sel_y = (state_q == ST_ACCUM) ? in_y : by_q[rd_idx];
    assign sel_r = (state_q == ST_ACCUM) ? in_r : br_q[rd_idx];

    hsf_sqrt #(.SLOPE_W(SLOPE_W), .FRAC(FRAC)) u_sqrt (
        .clk(clk), .rst_n(rst_n), .start(seed_take), .slope(seed_slope),
        .k_o(k_w), .done_o(sq_done)
    );

    hsf_intercept #(
        .COORD_W(COORD_W), .R_W(R_W), .SLOPE_W(SLOPE_W), .FRAC(FRAC),
        .NBINS(NBINS), .BIN_SHIFT(BIN_SHIFT)
    ) u_icpt (
        .k(k_w), .slope(m_q), .z(sel_z), .y(sel_y), .r(sel_r), .win_lo(win_q),
        .bp(bp_w), .bn(bn_w), .p_ok(p_ok_w), .n_ok(n_ok_w),
        .p_bin(p_bin_w), .n_bin(n_bin_w)
    );

    hsf_histo #(.NBINS(NBINS), .CNT_W(CNT_W)) u_histo (
        .clk(clk), .rst_n(rst_n), .clr(seed_take), .vote(hit_store),
        .p_ok(p_ok_w), .p_bin(p_bin_w), .n_ok(n_ok_w), .n_bin(n_bin_w),
        .rd_idx(scan_q), .rd_cnt(cur_cnt)
    );

    assign scan_last = (scan_q == BIN_W'(NBINS - 1));
    assign better    = cur_cnt > best_cnt_q;
    assign nb_cnt    = better ? cur_cnt : best_cnt_q;
    assign peak_ok   = (nb_cnt >= min_q) && (nb_cnt != '0);

    assign hit_p   = p_ok_w && (p_bin_w == best_bin_q);
    assign hit_n   = n_ok_w && (n_bin_w == best_bin_q);
    assign emit    = hit_p || hit_n;
    assign step    = (state_q == ST_REPLAY) && (!emit || out_ready);
    assign rd_last = (rd_q == n_q - N_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (seed_valid)             state_d = ST_SQRT;
            ST_SQRT:   if (sq_done)                state_d = ST_ACCUM;
            ST_ACCUM:  if (in_valid && in_last)    state_d = ST_PEAK;
            ST_PEAK:   if (scan_last)              state_d = peak_ok ? ST_REPLAY : ST_DONE;
            ST_REPLAY: if (step && rd_last)        state_d = ST_DONE;
            ST_DONE:                               state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        seed_ready = (state_q == ST_IDLE);
        in_ready   = (state_q == ST_ACCUM);
        out_valid  = (state_q == ST_REPLAY) && emit;
        seg_done   = (state_q == ST_DONE);
        out_z      = sel_z;
        out_y      = sel_y;
        out_r      = sel_r;
        out_b      = hit_p ? bp_w : bn_w;
        out_neg    = !hit_p;
    end

    assign seg_found    = found_q;
    assign seg_peak_bin = best_bin_q;
    assign seg_peak_cnt = best_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q        <= '0;
            win_q      <= '0;
            min_q      <= '0;
            n_q        <= '0;
            rd_q       <= '0;
            scan_q     <= '0;
            best_bin_q <= '0;
            best_cnt_q <= '0;
            found_q    <= 1'b0;
        end else begin
            if (seed_take) begin
                m_q   <= seed_slope;
                win_q <= cfg_win_lo;
                min_q <= cfg_min_cnt;
                n_q   <= '0;
            end
            if (hit_store) n_q <= n_q + 1'b1;
            if (hit_take && in_last) begin
                scan_q     <= '0;
                best_bin_q <= '0;
                best_cnt_q <= '0;
            end
            if (state_q == ST_PEAK) begin
                scan_q <= scan_q + 1'b1;
                if (better) begin
                    best_cnt_q <= cur_cnt;
                    best_bin_q <= scan_q;
                end
                if (scan_last) begin
                    found_q <= peak_ok;
                    rd_q    <= '0;
                end
            end
            if (step) rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (hit_store) begin
            bz_q[n_q[A_W-1:0]] <= in_z;
            by_q[n_q[A_W-1:0]] <= in_y;
            br_q[n_q[A_W-1:0]] <= in_r;
        end
    end
endmodule

// File: rtl/hsf_checks.sv
module hsf_checks #(
    parameter int COORD_W = 10,
    parameter int R_W     = 6,
    parameter int BW      = 20,
    parameter int CNT_W   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      seed_ready,
    input logic                      in_ready,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic signed [COORD_W-1:0] out_z,
    input logic        [R_W-1:0]     out_r,
    input logic signed [BW-1:0]      out_b,
    input logic                      out_neg,
    input logic                      seg_done,
    input logic                      seg_found,
    input logic        [CNT_W-1:0]   seg_peak_cnt
);
    // R8: a stalled output keeps its contents
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_b) && $stable(out_z) && $stable(out_neg));

    // R10: end pulse is a single cycle and quiet on both streams
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |=> !seg_done);
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |-> !out_valid && !in_ready);
    a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(seed_ready && in_ready));

    // R7: a hit with zero radius has equal intercepts, so the positive side is taken
    a_r7_neg_radius: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_neg |-> out_r != '0);

    // R6: emitted hits only while a segment is found; a found peak is never empty
    a_r6_emit_found: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seg_found);
    a_r6_found_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done && seg_found |-> seg_peak_cnt != '0);
endmodule

bind hough_seg_finder hsf_checks #(
    .COORD_W(COORD_W), .R_W(R_W), .BW(COORD_W + SLOPE_W + 2), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .seed_ready(seed_ready), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_z(out_z), .out_r(out_r),
    .out_b(out_b), .out_neg(out_neg), .seg_done(seg_done), .seg_found(seg_found),
    .seg_peak_cnt(seg_peak_cnt)
);

// File: tb/sim_hough_seg_finder.sv
module sim_hough_seg_finder;
    localparam int NB = 16;
    localparam int DP = 8;
    localparam int CMAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seed_valid = 1'b0;
    logic signed [7:0] seed_slope = '0;
    logic signed [9:0] cfg_win_lo = '0;
    logic [2:0] cfg_min_cnt = '0;
    logic in_valid = 1'b0;
    logic signed [9:0] in_z = '0, in_y = '0;
    logic [5:0] in_r = '0;
    logic in_last = 1'b0;
    logic out_ready = 1'b1;
    logic seed_ready, in_ready, out_valid, out_neg, seg_done, seg_found;
    logic signed [9:0] out_z, out_y;
    logic [5:0] out_r;
    logic signed [19:0] out_b;
    logic [3:0] seg_peak_bin;
    logic [2:0] seg_peak_cnt;

    always #2 clk = ~clk;

    hough_seg_finder u0 (
        .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_ready(seed_ready),
        .seed_slope(seed_slope), .cfg_win_lo(cfg_win_lo), .cfg_min_cnt(cfg_min_cnt),
        .in_valid(in_valid), .in_ready(in_ready), .in_z(in_z), .in_y(in_y), .in_r(in_r),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_z(out_z),
        .out_y(out_y), .out_r(out_r), .out_b(out_b), .out_neg(out_neg), .seg_done(seg_done),
        .seg_found(seg_found), .seg_peak_bin(seg_peak_bin), .seg_peak_cnt(seg_peak_cnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    int hz [16];
    int hy [16];
    int hr [16];
    int nh = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int isqrt(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    function automatic int bval(input int k, input int m, input int z, input int y, input int r, input bit neg);
        int kr = (k * r) >>> 4;
        int mz = (m * z) >>> 4;
        return neg ? (y - kr - mz) : (y + kr - mz);
    endfunction

    function automatic int bin_of(input int b, input int w);
        int off = b - w;
        if (off < 0 || (off >>> 2) >= NB) return -1;
        return off >>> 2;
    endfunction

    task automatic mk_line(input int m, input int base);
        nh = 6;
        for (int i = 0; i < 6; i++) begin
            hz[i] = i * 37 - 90;
            hr[i] = (i * 5 + 3) % 20;
            hy[i] = ((m * hz[i]) >>> 4) + base + ((i % 2) ? hr[i] : -hr[i]);
            if (i == 5) hy[i] += 150;
        end
    endtask

    task automatic run_event(input int m, input int w, input int mn, input int stall, input string ctx);
        int k, stored, best, bb, ne, got, cyc;
        int hist [NB];
        int ez [16];
        int eb [16];
        int en [16];
        bit found, fin;
        k = isqrt(256 + m * m);
        stored = (nh < DP) ? nh : DP;
        for (int i = 0; i < NB; i++) hist[i] = 0;
        for (int i = 0; i < stored; i++) begin
            for (int s = 0; s < 2; s++) begin
                int bi = bin_of(bval(k, m, hz[i], hy[i], hr[i], s[0]), w);
                if (bi >= 0 && hist[bi] < CMAX) hist[bi]++;
            end
        end
        best = 0; bb = 0;
        for (int i = 0; i < NB; i++) if (hist[i] > best) begin best = hist[i]; bb = i; end
        found = (best >= mn) && (best != 0);
        ne = 0;
        if (found) begin
            for (int i = 0; i < stored; i++) begin
                int bp = bval(k, m, hz[i], hy[i], hr[i], 1'b0);
                int bn = bval(k, m, hz[i], hy[i], hr[i], 1'b1);
                if (bin_of(bp, w) == bb) begin ez[ne] = hz[i]; eb[ne] = bp; en[ne] = 0; ne++; end
                else if (bin_of(bn, w) == bb) begin ez[ne] = hz[i]; eb[ne] = bn; en[ne] = 1; ne++; end
            end
        end

        @(negedge clk);
        seed_slope = 8'(m); cfg_win_lo = 10'(w); cfg_min_cnt = 3'(mn); seed_valid = 1'b1;
        chk(seed_ready == 1'b1, {ctx, " R10 seed_ready idle"}, int'(seed_ready), 1);
        @(negedge clk);
        seed_valid = 1'b0;
        chk(in_ready == 1'b0 && seed_ready == 1'b0, {ctx, " R10 ready in sqrt"}, int'(in_ready), 0);
        for (int i = 0; i < nh; i++) begin
            in_z = 10'(hz[i]); in_y = 10'(hy[i]); in_r = 6'(hr[i]);
            in_last = (i == nh - 1); in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        got = 0; cyc = 0; fin = 1'b0;
        while (!fin && cyc < 400) begin
            out_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
            if (out_valid && out_ready) begin
                if (got < ne) begin
                    chk(int'(out_z) == ez[got], {ctx, " R7 order z"}, int'(out_z), ez[got]);
                    chk(int'(out_b) == eb[got], {ctx, " R2 intercept"}, int'(out_b), eb[got]);
                    chk(int'(out_neg) == en[got], {ctx, " R7 side tag"}, int'(out_neg), en[got]);
                end
                got++;
            end
            if (seg_done) begin
                fin = 1'b1;
                chk(seg_found == found, {ctx, " R6 found"}, int'(seg_found), int'(found));
                chk(int'(seg_peak_cnt) == best, {ctx, " R4 peak count"}, int'(seg_peak_cnt), best);
                chk(int'(seg_peak_bin) == bb, {ctx, " R5 peak bin"}, int'(seg_peak_bin), bb);
                chk(got == ne, {ctx, " R8 hit total"}, got, ne);
                if (stall == 0)
                    chk(cyc == (found ? NB + stored : NB), {ctx, " R10 done latency"}, cyc,
                        found ? NB + stored : NB);
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(fin, {ctx, " R10 done seen"}, int'(fin), 1);
        out_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired R10 actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(seed_ready == 1'b1, "R1 seed_ready", int'(seed_ready), 1);
        chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(seg_done == 1'b0, "R1 seg_done", int'(seg_done), 0);
        rst_n = 1'b1;

        // R2 R7 slope sweep over the full small slope range
        for (int m = -8; m <= 8; m++) begin
            mk_line(m, 30);
            run_event(m, 0, 2, 0, "sweep");
        end

        // R8 backpressure with two stall patterns
        mk_line(3, 30);  run_event(3, 0, 2, 3, "stall3");
        mk_line(-5, 20); run_event(-5, 0, 1, 2, "stall2");

        // R5 tie: two bins with two votes each, lowest index wins
        nh = 2;
        hz[0] = 0; hy[0] = 4;  hr[0] = 0;
        hz[1] = 0; hy[1] = 40; hr[1] = 0;
        run_event(0, 0, 1, 0, "tie R5");

        // R6 peak below the programmed minimum
        mk_line(2, 30);
        run_event(2, 0, 7, 0, "below-min R6");

        // R3 window placed above and below all intercepts
        mk_line(0, 30);
        run_event(0, 300, 0, 0, "win-high R3");
        run_event(0, -100, 0, 0, "win-low R3");

        // R4 saturation then clearing on the next seed
        nh = 5;
        for (int i = 0; i < 5; i++) begin hz[i] = 0; hy[i] = 10; hr[i] = 0; end
        run_event(0, 0, 1, 0, "saturate R4");
        nh = 1;
        run_event(0, 0, 1, 0, "clear R4");

        // R9 hits past the buffer depth have no effect
        nh = 11;
        for (int i = 0; i < 11; i++) begin
            hz[i] = 0; hr[i] = 0;
            hy[i] = (i < DP) ? i * 8 : 60;
        end
        run_event(0, 0, 1, 0, "overflow R9");

        summary();
    end
endmodule